// File: doc/BRIEF.md
# Sync-gated DAC sample front end with waveform generator

This block sits between a bus register write port and the input latch of a 12-bit digital-to-analog converter. A 16-bit word written into its data register is cut down to a 12-bit code. A format control selects whether the code is taken from the low twelve bits or the high twelve bits of the word. In the manual path the code reaches the converter either on the clock edge after the register captures it (free-running mode) or only when an external sync line rises (gated mode).

In automatic mode the block ignores the data register and generates the code itself. The waveform engine is a four-state machine: `WG_IDLE` (automatic mode off), `WG_UP` (ascending), `WG_DOWN` (descending) and `WG_HOLD` (no direction enabled). The engine moves by a step value between a lower and an upper limit. With only the upward enable set it produces a rising sawtooth. With only the downward enable set it produces a falling sawtooth. With both set it produces a triangle.

Transitions of the engine:
- `WG_IDLE` goes to `WG_UP`, `WG_DOWN` or `WG_HOLD` on entry, which loads the lower limit.
- Any state returns to `WG_IDLE` when the automatic enable drops.
- `WG_UP` goes to `WG_DOWN` at the upper limit when both directions are enabled. It wraps to the lower limit in place when only upward counting is enabled.
- `WG_DOWN` goes to `WG_UP` at the lower limit when both directions are enabled. It wraps to the upper limit when only downward counting is enabled.
- A state whose direction has been disabled moves to the other direction, or to `WG_HOLD`.
- `WG_HOLD` leaves when a direction is enabled again.

The engine moves once per clock in free-running mode and once per sync rising edge in gated mode. A further output flags a glitch-filter request as illegal in the one mode where a filter would freeze the output: automatic mode that moves on every clock.

Top module: `dac_wavefront`

## Requirements
- R1: After reset, `dac_code` is 0 and `filt_bad` is 0.
- R2: With `fmt_left`=0, the code is `wr_data[11:0]` of the last written word, and bits 15:12 have no effect.
- R3: With `fmt_left`=1, the code is `wr_data[15:4]` of the last written word, and bits 3:0 have no effect.
- R4: With `sync_en`=0 and `auto_en`=0, a word written at clock edge k appears on `dac_code` after edge k+1 and not before.
- R5: With `sync_en`=1 and `auto_en`=0, `dac_code` keeps its value until `sync_in` rises. It then takes the current code after the third clock edge that samples `sync_in` high. A `sync_in` held high or low causes no further update.
- R6: On the first clock edge at which `auto_en` is 1, `dac_code` becomes `min_val`.
- R7: With only `up_en` set, each move adds `step_val`. A move that would pass `max_val` gives `max_val` instead. The next move from `max_val` gives `min_val`.
- R8: With only `down_en` set, each move subtracts `step_val`. A move that would pass below `min_val` gives `min_val` instead. The next move from `min_val` gives `max_val`.
- R9: With both enables set, the engine starts upward, saturates at each limit and reverses at that limit on the next move, giving a triangle.
- R10: In automatic mode with `sync_en`=1, the engine moves exactly once per `sync_in` rising edge, with the same three-edge latency as in R5. With `sync_en`=0 it moves on every clock edge.
- R11: While automatic mode runs with `min_val` <= `max_val`, `dac_code` stays within [`min_val`, `max_val`].
- R12: `filt_bad` is 1 exactly when `filt_req`=1, `auto_en`=1 and `sync_en`=0.
- R13: On the first clock edge after `auto_en` drops, `dac_code` returns to the manual path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 16 | Word to store in the data register |
| fmt_left | input | 1 | 1: code in bits 15:4; 0: code in bits 11:0 |
| sync_en | input | 1 | 1: updates wait for a `sync_in` rising edge |
| sync_in | input | 1 | Asynchronous update trigger |
| auto_en | input | 1 | Enables the waveform engine |
| up_en | input | 1 | Permits upward moves |
| down_en | input | 1 | Permits downward moves |
| step_val | input | 12 | Size of each move |
| min_val | input | 12 | Lower waveform limit |
| max_val | input | 12 | Upper waveform limit |
| filt_req | input | 1 | Glitch-filter enable request |
| dac_code | output | 12 | Code for the converter |
| filt_bad | output | 1 | Filter request is illegal in the current mode |

## Verification
A wrong direction state or a missed reversal appears on `dac_code` at the next move. In free-running automatic mode that is the next clock edge. In gated mode it is three edges after the next sync rise. So the bench compares every move of several sawtooth and triangle runs, across many step sizes, against an arithmetic model. A synchronizer or edge detector that fires twice, or not at all, shows as a code that changes while `sync_in` is steady, or that stays stuck after a rise. Justification slips show on the first write that carries distinct bits in the ignored nibble.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    typedef enum logic [1:0] {
        WG_IDLE = 2'd0,
        WG_UP   = 2'd1,
        WG_DOWN = 2'd2,
        WG_HOLD = 2'd3
    } wg_state_t;

endpackage

// File: rtl/dacw_sync.sv
module dacw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

    // R5: an edge pulse lasts one cycle only
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/dacw_justify.sv
module dacw_justify #(
    parameter int DW = 16,
    parameter int CW = 12
) (
    input  logic [DW-1:0] word,
    input  logic          left,
    output logic [CW-1:0] code
);
    localparam int SHIFT = DW - CW;

    generate
        if (SHIFT == 0) begin : g_same
            assign code = word;
        end else begin : g_pick
            assign code = left ? word[DW-1:SHIFT] : word[CW-1:0];
        end
    endgenerate

endmodule

// File: rtl/dacw_wavegen.sv
module dacw_wavegen
    import dacw_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          up_en,
    input  logic          down_en,
    input  logic [CW-1:0] step_val,
    input  logic [CW-1:0] min_val,
    input  logic [CW-1:0] max_val,
    output logic          active,
    output logic [CW-1:0] wave
);
    wg_state_t     st_q, st_n;
    logic [CW-1:0] val_q, val_n, val_pre;
    logic [CW:0]   add_sum, floor_sum;
    logic          up_over, dn_under;
    logic [CW-1:0] up_sat, dn_sat;

    assign add_sum   = {1'b0, val_q} + {1'b0, step_val};
    assign floor_sum = {1'b0, min_val} + {1'b0, step_val};
    assign up_over   = add_sum > {1'b0, max_val};
    assign dn_under  = {1'b0, val_q} < floor_sum;
    assign up_sat    = up_over ? max_val : add_sum[CW-1:0];
    assign dn_sat    = dn_under ? min_val : (val_q - step_val);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WG_IDLE;
            val_q <= '0;
        end else begin
            st_q  <= st_n;
            val_q <= val_n;
        end
    end

    // next state and value
    always_comb begin
        st_n    = st_q;
        val_pre = val_q;
        if (!run) begin
            st_n = WG_IDLE;
        end else begin
            unique case (st_q)
                WG_IDLE: begin
                    val_pre = min_val;
                    if (up_en)        st_n = WG_UP;
                    else if (down_en) st_n = WG_DOWN;
                    else              st_n = WG_HOLD;
                end
                WG_UP: begin
                    if (tick) begin
                        if (!up_en) begin
                            st_n = down_en ? WG_DOWN : WG_HOLD;
                        end else if (!up_over) begin
                            val_pre = add_sum[CW-1:0];
                        end else if (val_q < max_val) begin
                            val_pre = max_val;
                        end else if (down_en) begin
                            st_n    = WG_DOWN;
                            val_pre = dn_sat;
                        end else begin
                            val_pre = min_val;
                        end
                    end
                end
                WG_DOWN: begin
                    if (tick) begin
                        if (!down_en) begin
                            st_n = up_en ? WG_UP : WG_HOLD;
                        end else if (!dn_under) begin
                            val_pre = val_q - step_val;
                        end else if (val_q > min_val) begin
                            val_pre = min_val;
                        end else if (up_en) begin
                            st_n    = WG_UP;
                            val_pre = up_sat;
                        end else begin
                            val_pre = max_val;
                        end
                    end
                end
                WG_HOLD: begin
                    if (tick) begin
                        if (up_en)        st_n = WG_UP;
                        else if (down_en) st_n = WG_DOWN;
                    end
                end
            endcase
        end
    end

    // output value with limit clamp whenever the engine runs
    always_comb begin
        val_n = val_pre;
        if (st_n != WG_IDLE) begin
            if (val_pre > max_val)      val_n = max_val;
            else if (val_pre < min_val) val_n = min_val;
        end
    end

    assign active = (st_q != WG_IDLE);
    assign wave   = val_q;

    // R6: entry loads the lower limit
    p_entry_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WG_IDLE && run && min_val <= max_val) |=> (val_q == $past(min_val)));

    // R11: value held inside the limits while they are steady
    p_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != WG_IDLE && $stable(min_val) && $stable(max_val) && min_val <= max_val)
        |-> (val_q >= min_val && val_q <= max_val));

endmodule

// File: rtl/dac_wavefront.sv
module dac_wavefront #(
    parameter int DW          = 16,
    parameter int CW          = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          fmt_left,
    input  logic          sync_en,
    input  logic          sync_in,
    input  logic          auto_en,
    input  logic          up_en,
    input  logic          down_en,
    input  logic [CW-1:0] step_val,
    input  logic [CW-1:0] min_val,
    input  logic [CW-1:0] max_val,
    input  logic          filt_req,
    output logic [CW-1:0] dac_code,
    output logic          filt_bad
);
    logic [DW-1:0] data_q;
    logic [CW-1:0] sample;
    logic [CW-1:0] manual_q;
    logic [CW-1:0] wave;
    logic          sync_rise;
    logic          wave_active;
    logic          tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     data_q <= '0;
        else if (wr_en) data_q <= wr_data;
    end

    dacw_justify #(.DW(DW), .CW(CW)) u_just (
        .word (data_q),
        .left (fmt_left),
        .code (sample)
    );

    dacw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .rise     (sync_rise)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     manual_q <= '0;
        else if (!sync_en || sync_rise) manual_q <= sample;
    end

    assign tick = sync_en ? sync_rise : 1'b1;

    dacw_wavegen #(.CW(CW)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (auto_en),
        .tick     (tick),
        .up_en    (up_en),
        .down_en  (down_en),
        .step_val (step_val),
        .min_val  (min_val),
        .max_val  (max_val),
        .active   (wave_active),
        .wave     (wave)
    );

    assign dac_code = wave_active ? wave : manual_q;
    assign filt_bad = filt_req & auto_en & ~sync_en;

    // R4: free-running manual path follows the justified word one edge later
    p_async_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !sync_en) |=> (dac_code == $past(sample)));

    // R5: gated manual register is frozen without a sync edge
    p_sync_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && !sync_rise) |=> $stable(manual_q));

endmodule

// File: tb/dac_wavefront_test.sv
module dac_wavefront_test;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        fmt_left = 1'b0;
    logic        sync_en = 1'b0;
    logic        sync_in = 1'b0;
    logic        auto_en = 1'b0;
    logic        up_en = 1'b0;
    logic        down_en = 1'b0;
    logic [11:0] step_val = '0;
    logic [11:0] min_val = '0;
    logic [11:0] max_val = '0;
    logic        filt_req = 1'b0;
    logic [11:0] dac_code;
    logic        filt_bad;

    int checks = 0;
    int errors = 0;
    int mv, mdir, cycles;

    always #(CLK_T/2) clk = ~clk;

    dac_wavefront uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fmt_left(fmt_left), .sync_en(sync_en), .sync_in(sync_in),
        .auto_en(auto_en), .up_en(up_en), .down_en(down_en),
        .step_val(step_val), .min_val(min_val), .max_val(max_val),
        .filt_req(filt_req), .dac_code(dac_code), .filt_bad(filt_bad)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // arithmetic model of one waveform move: mdir 0 up, 1 down, 2 hold
    task automatic model_move();
        int lo = int'(min_val);
        int hi = int'(max_val);
        int st = int'(step_val);
        if (mdir == 0) begin
            if (mv + st > hi) begin
                if (mv < hi) mv = hi;
                else if (down_en) begin
                    mdir = 1;
                    mv = (mv - st >= lo) ? mv - st : lo;
                end else mv = lo;
            end else mv = mv + st;
        end else if (mdir == 1) begin
            if (mv - st < lo) begin
                if (mv > lo) mv = lo;
                else if (up_en) begin
                    mdir = 0;
                    mv = (mv + st <= hi) ? mv + st : hi;
                end else mv = hi;
            end else mv = mv - st;
        end
    endtask

    task automatic enter_auto(input string tag);
        auto_en = 1'b1;
        cyc(1);
        mv = int'(min_val);
        mdir = up_en ? 0 : (down_en ? 1 : 2);
        chk(dac_code == min_val, tag, dac_code, min_val);
    endtask

    task automatic leave_auto();
        auto_en = 1'b0;
        cyc(1);
    endtask

    task automatic run_free(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1);
            model_move();
            chk(int'(dac_code) == mv, tag, dac_code, mv);
            chk(dac_code >= min_val && dac_code <= max_val, "R11", dac_code, mv);
        end
    endtask

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int prev;
        int expv;
        logic [15:0] w;
        cyc(2);
        chk(dac_code == 0, "R1 code", dac_code, 0);
        chk(filt_bad == 0, "R1 flag", filt_bad, 0);
        rst_n = 1'b1;
        cyc(1);
        chk(dac_code == 0, "R1 after release", dac_code, 0);

        // R2 / R3 / R4 sweeps in free-running manual mode
        prev = 0;
        for (int f = 0; f < 2; f++) begin
            fmt_left = f[0];
            cyc(1);
            prev = int'(dac_code);
            for (int i = 0; i < 24; i++) begin
                w = 16'(i * 16'h1357) ^ 16'hA5C3;
                wr_data = w;
                wr_en = 1'b1;
                @(posedge clk);
                @(negedge clk);
                wr_en = 1'b0;
                chk(int'(dac_code) == prev, "R4 not early", dac_code, prev);
                cyc(1);
                expv = f ? int'(w[15:4]) : int'(w[11:0]);
                chk(int'(dac_code) == expv, f ? "R3" : "R2", dac_code, expv);
                prev = expv;
            end
        end
        fmt_left = 1'b0;

        // R5 gated manual path
        sync_en = 1'b1;
        wr_data = 16'hF123; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
        cyc(4);
        chk(int'(dac_code) == prev, "R5 held", dac_code, prev);
        sync_in = 1'b1;
        cyc(2);
        chk(int'(dac_code) == prev, "R5 not yet", dac_code, prev);
        cyc(1);
        chk(dac_code == 12'h123, "R5 update", dac_code, 12'h123);
        wr_data = 16'h0456; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
        cyc(5);
        chk(dac_code == 12'h123, "R5 high steady", dac_code, 12'h123);
        sync_in = 1'b0;
        cyc(5);
        chk(dac_code == 12'h123, "R5 low steady", dac_code, 12'h123);
        sync_in = 1'b1;
        cyc(3);
        chk(dac_code == 12'h456, "R5 second rise", dac_code, 12'h456);
        sync_in = 1'b0;
        sync_en = 1'b0;
        cyc(3);

        // R7 rising sawtooth across steps
        up_en = 1'b1; down_en = 1'b0;
        min_val = 12'd5; max_val = 12'd50;
        for (int s = 1; s <= 13; s++) begin
            step_val = 12'(s);
            enter_auto("R6 entry up");
            run_free(40, "R7 sawtooth up");
            leave_auto();
            chk(dac_code == 12'h456, "R13 manual after auto", dac_code, 12'h456);
        end

        // R8 falling sawtooth
        up_en = 1'b0; down_en = 1'b1;
        min_val = 12'd100; max_val = 12'd160;
        for (int s = 3; s <= 15; s += 2) begin
            step_val = 12'(s);
            enter_auto("R6 entry down");
            run_free(40, "R8 sawtooth down");
            leave_auto();
        end

        // R9 triangle
        up_en = 1'b1; down_en = 1'b1;
        min_val = 12'd10; max_val = 12'd40;
        for (int s = 1; s <= 12; s++) begin
            step_val = 12'(s);
            enter_auto("R6 entry tri");
            run_free(50, "R9 triangle");
            leave_auto();
        end

        // R10 moves gated by sync edges
        sync_en = 1'b1;
        step_val = 12'd6;
        enter_auto("R6 entry gated");
        for (int p = 0; p < 16; p++) begin
            sync_in = 1'b1;
            cyc(2);
            chk(int'(dac_code) == mv, "R10 wait", dac_code, mv);
            cyc(1);
            model_move();
            chk(int'(dac_code) == mv, "R10 move", dac_code, mv);
            cyc(2);
            sync_in = 1'b0;
            cyc(3);
            chk(int'(dac_code) == mv, "R10 steady", dac_code, mv);
        end
        leave_auto();
        sync_en = 1'b0;

        // R12 filter legality across all mode combinations
        for (int c = 0; c < 8; c++) begin
            filt_req = c[0];
            auto_en  = c[1];
            sync_en  = c[2];
            #1;
            chk(filt_bad == (c[0] & c[1] & ~c[2]), "R12", filt_bad, c[0] & c[1] & ~c[2]);
            cyc(1);
        end
        filt_req = 1'b0; auto_en = 1'b0; sync_en = 1'b0;
        cyc(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule